// File: doc/BRIEF.md
# Eight-Level Prioritized Interrupt Controller

This block gathers up to eight interrupt request lines and gives them to a processor one at a time, highest priority first. A processor sets it up through a byte-wide register port with two addresses, a command address and a data address. Initialization works as a short write sequence that begins with a command byte carrying bit 4. Once that sequence is done, later command writes either acknowledge the end of a service routine or choose what a command read returns. Data writes load the mask.

Each rising edge on a request line sets that level's pending bit. When the best unmasked pending level outranks everything already in service, the block raises its interrupt output. On an acknowledge pulse it moves the winning level from pending to in-service and presents an 8-bit vector, which is that level added to a programmed base. A one-cycle error flag marks every register write the block refuses. A refused write changes nothing.

Top module: `pic_core`

## Requirements
- R1: A command-address write with bit 4 set is accepted in any sequencer state and starts initialization. The next data-address write is then taken as the vector base and not as a mask.
- R2: Initialization data writes arrive in a fixed order. The base comes first. A second write follows when bit 1 of the starting command byte is 0. A further write follows when its bit 0 is 1. After these the block is ready. Only the base write has an effect, and none of these writes changes the mask.
- R3: In the ready state a data-address write loads the mask (bit n masks level n), and a data-address read returns the mask.
- R4: The block refuses a write and raises `err_o` for exactly the following cycle in three cases. The first is a data-address write while waiting for the starting command byte. The second is a command-address write with bit 4 clear outside the ready state. The third is a command write with bits 4:3 = 00 that is not a plain end-of-interrupt (bits 7:5 other than 001). A refused write changes no register.
- R5: A command write in the ready state with bits 7:3 = 00100 clears only the lowest-numbered set bit of the in-service register.
- R6: A command write in the ready state with bits 4:3 = 01 and bit 1 = 1 picks the command-read source: bit 0 = 1 picks in-service and bit 0 = 0 picks pending. With bit 1 = 0 the current choice is kept. Reset picks pending.
- R7: A rising edge on `irq_in[n]` sets pending bit n. Only an acknowledge of level n clears that bit. Masking hides the bit but does not clear it.
- R8: Level 0 has the highest priority. `int_o` is high, one cycle after the registers settle, exactly when the block is ready and the lowest-numbered unmasked pending level is lower than every in-service level.
- R9: An `ack_i` pulse while the interrupt condition holds clears that level's pending bit and sets its in-service bit. On the next cycle it gives `vec_valid_o` = 1 and `vector_o` = (base + level) mod 256. An acknowledge without that condition changes nothing and leaves `vec_valid_o` low.
- R10: After reset the pending, in-service and mask registers are zero, the base is zero, the sequencer waits for the starting command byte, and `int_o`, `err_o` and `vec_valid_o` are low.
- R11: Read data appears on `bus_rdata` in the cycle after `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 1 | 0 = command address, 1 = data address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_in | input | NUM_LVL | Request lines, rising-edge sensitive |
| int_o | output | 1 | Interrupt to the processor |
| ack_i | input | 1 | Acknowledge pulse |
| vec_valid_o | output | 1 | Vector valid, one cycle after a granted acknowledge |
| vector_o | output | 8 | Vector of the granted level |
| err_o | output | 1 | One-cycle pulse for a refused write |

## Verification
The assertions check several rules on every cycle. The starting command byte always leads to the base-wait state. A refused write leaves the sequencer where it was. Pending bits clear only through an acknowledge. An accepted end-of-interrupt removes exactly one in-service bit. A granted acknowledge is always followed by a valid vector. The interrupt stays low while the block is not ready. Other properties come only from the bench's scenarios: the exact vector arithmetic with base wrap-around, the full priority order across all eight levels, nested service, the read-source selection, and the fact that initialization and refused writes leave the mask and in-service contents untouched.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int DATA_W     = 8;
  localparam int CW_START   = 4;   // command bit that starts initialization
  localparam int CW_SNGL    = 1;   // starting byte: 1 = no third init write
  localparam int CW_FOURTH  = 0;   // starting byte: 1 = a fourth init write follows
  localparam int CW_EOI     = 5;
  localparam int CW_SL      = 6;
  localparam int CW_ROT     = 7;
  localparam int CW_RDSEL_EN = 1;
  localparam int CW_RDSEL   = 0;

  typedef enum logic [2:0] {
    SQ_WAIT_START = 3'd0,
    SQ_WAIT_BASE  = 3'd1,
    SQ_WAIT_THIRD = 3'd2,
    SQ_WAIT_FOURTH = 3'd3,
    SQ_READY      = 3'd4
  } seq_st_t;
endpackage

// File: rtl/pic_edge.sv
module pic_edge #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) prev_q[g] <= 1'b0;
      else     prev_q[g] <= lvl_i[g];
    end
    assign rise_o[g] = lvl_i[g] & ~prev_q[g];
  end
endmodule

// File: rtl/pic_lowest.sv
module pic_lowest #(
  parameter int N  = 8,
  localparam int LW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [LW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = LW'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/pic_seq.sv
module pic_seq
  import pic_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] base_o,
  output logic              eoi_o,
  output logic              rdsel_we_o,
  output logic              mask_we_o,
  output logic              err_o
);
  seq_st_t st_q, st_d;
  logic sngl_q, fourth_q;
  logic start_ld, base_ld;
  logic [DATA_W-1:0] base_q;

  always_comb begin
    st_d       = st_q;
    start_ld   = 1'b0;
    base_ld    = 1'b0;
    eoi_o      = 1'b0;
    rdsel_we_o = 1'b0;
    mask_we_o  = 1'b0;
    err_o      = 1'b0;
    if (wr_i && !addr_i) begin
      if (wdata_i[CW_START]) begin
        start_ld = 1'b1;
        st_d     = SQ_WAIT_BASE;
      end else if (st_q == SQ_READY) begin
        if (wdata_i[4:3] == 2'b00) begin
          if (wdata_i[CW_EOI] && !wdata_i[CW_SL] && !wdata_i[CW_ROT]) eoi_o = 1'b1;
          else                                                       err_o = 1'b1;
        end else begin
          rdsel_we_o = 1'b1;
        end
      end else begin
        err_o = 1'b1;
      end
    end else if (wr_i && addr_i) begin
      case (st_q)
        SQ_WAIT_BASE: begin
          base_ld = 1'b1;
          if (!sngl_q)      st_d = SQ_WAIT_THIRD;
          else if (fourth_q) st_d = SQ_WAIT_FOURTH;
          else              st_d = SQ_READY;
        end
        SQ_WAIT_THIRD:  st_d = fourth_q ? SQ_WAIT_FOURTH : SQ_READY;
        SQ_WAIT_FOURTH: st_d = SQ_READY;
        SQ_READY:       mask_we_o = 1'b1;
        default:        err_o = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= SQ_WAIT_START;
      sngl_q   <= 1'b0;
      fourth_q <= 1'b0;
      base_q   <= '0;
    end else begin
      st_q <= st_d;
      if (start_ld) begin
        sngl_q   <= wdata_i[CW_SNGL];
        fourth_q <= wdata_i[CW_FOURTH];
      end
      if (base_ld) base_q <= wdata_i;
    end
  end

  assign ready_o = (st_q == SQ_READY);
  assign base_o  = base_q;

  assert_start_any_state_R1: assert property (@(posedge clk) disable iff (rst)
    (wr_i && !addr_i && wdata_i[CW_START]) |=> (st_q == SQ_WAIT_BASE));

  assert_refused_keeps_state_R4: assert property (@(posedge clk) disable iff (rst)
    err_o |=> $stable(st_q));

  assert_ready_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (st_q == SQ_READY && !(wr_i && !addr_i && wdata_i[CW_START])) |=> (st_q == SQ_READY));
endmodule

// File: rtl/pic_core.sv
module pic_core
  import pic_pkg::*;
#(
  parameter int NUM_LVL = 8,
  localparam int LVL_W = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic               bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_LVL-1:0] irq_in,
  output logic               int_o,
  input  logic               ack_i,
  output logic               vec_valid_o,
  output logic [DATA_W-1:0]  vector_o,
  output logic               err_o
);
  logic [NUM_LVL-1:0] irr_q, isr_q, imr_q, rise, pend;
  logic [NUM_LVL-1:0] ack_bit, eoi_bit;
  logic               rd_isr_q;
  logic               seq_ready, eoi_go, rdsel_we, mask_we, seq_err;
  logic [DATA_W-1:0]  base;
  logic               p_any, s_any, grant, ack_hit;
  logic [LVL_W-1:0]   p_idx, s_idx;

  pic_seq u_seq (
    .clk, .rst,
    .wr_i(bus_wr), .addr_i(bus_addr), .wdata_i(bus_wdata),
    .ready_o(seq_ready), .base_o(base), .eoi_o(eoi_go),
    .rdsel_we_o(rdsel_we), .mask_we_o(mask_we), .err_o(seq_err)
  );

  pic_edge #(.N(NUM_LVL)) u_edge (.clk, .rst, .lvl_i(irq_in), .rise_o(rise));

  assign pend = irr_q & ~imr_q;

  pic_lowest #(.N(NUM_LVL)) u_pend_pick (.req_i(pend),  .any_o(p_any), .idx_o(p_idx));
  pic_lowest #(.N(NUM_LVL)) u_serv_pick (.req_i(isr_q), .any_o(s_any), .idx_o(s_idx));

  assign grant   = seq_ready && p_any && (!s_any || (p_idx < s_idx));
  assign ack_hit = ack_i && grant;
  assign ack_bit = ack_hit ? (NUM_LVL'(1) << p_idx) : '0;
  assign eoi_bit = eoi_go ? (isr_q & (~isr_q + NUM_LVL'(1))) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      irr_q       <= '0;
      isr_q       <= '0;
      imr_q       <= '0;
      rd_isr_q    <= 1'b0;
      int_o       <= 1'b0;
      err_o       <= 1'b0;
      vec_valid_o <= 1'b0;
      vector_o    <= '0;
      bus_rdata   <= '0;
    end else begin
      irr_q <= (irr_q & ~ack_bit) | rise;
      isr_q <= (isr_q & ~eoi_bit) | ack_bit;
      if (mask_we) imr_q <= bus_wdata[NUM_LVL-1:0];
      if (rdsel_we && bus_wdata[CW_RDSEL_EN]) rd_isr_q <= bus_wdata[CW_RDSEL];
      int_o       <= grant;
      err_o       <= seq_err;
      vec_valid_o <= ack_hit;
      if (ack_hit) vector_o <= base + DATA_W'(p_idx);
      if (bus_rd) begin
        if (bus_addr)      bus_rdata <= DATA_W'(imr_q);
        else if (rd_isr_q) bus_rdata <= DATA_W'(isr_q);
        else               bus_rdata <= DATA_W'(irr_q);
      end
    end
  end

  assert_eoi_one_bit_R5: assert property (@(posedge clk) disable iff (rst)
    (eoi_go && !ack_hit && isr_q != '0) |=>
      ($countones(isr_q) == $countones($past(isr_q)) - 1));

  assert_ack_gives_vector_R9: assert property (@(posedge clk) disable iff (rst)
    ack_hit |=> (vec_valid_o && isr_q != '0));

  assert_no_int_unready_R8: assert property (@(posedge clk) disable iff (rst)
    !seq_ready |=> !int_o);

  assert_pending_kept_R7: assert property (@(posedge clk) disable iff (rst)
    !ack_i |=> ((irr_q & $past(irr_q)) == $past(irr_q)));
endmodule

// File: tb/pic_core_tb_top.sv
module pic_core_tb_top;
  localparam int CLK_P = 10;
  localparam int NL = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_wr = 0, bus_rd = 0, bus_addr = 0, ack_i = 0;
  logic [7:0] bus_wdata = '0, bus_rdata, vector_o;
  logic [NL-1:0] irq_in = '0;
  logic int_o, vec_valid_o, err_o;
  int checks = 0, failures = 0;
  logic e, vv;
  logic [7:0] rv, vec;

  always #(CLK_P/2) clk = ~clk;

  pic_core #(.NUM_LVL(NL)) dut_i (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d, output logic err);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0; err = err_o;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  task automatic raise(input logic [NL-1:0] m);
    @(negedge clk); irq_in = m;
    @(negedge clk); irq_in = '0;
    @(negedge clk);
  endtask

  task automatic ack(output logic v, output logic [7:0] vc);
    @(negedge clk); ack_i = 1;
    @(negedge clk); ack_i = 0; v = vec_valid_o; vc = vector_o;
    @(negedge clk);
  endtask

  task automatic init(input logic [7:0] c1, input logic [7:0] b);
    wr(0, c1, e); chk("R1 start byte accepted", e, 0);
    wr(1, b, e);  chk("R2 base write accepted", e, 0);
    if (!c1[1]) begin wr(1, 8'h00, e); chk("R2 third write", e, 0); end
    if (c1[0])  begin wr(1, 8'h00, e); chk("R2 fourth write", e, 0); end
  endtask

  task automatic eoi();
    wr(0, 8'h20, e); chk("R5 eoi accepted", e, 0);
    @(negedge clk);
  endtask

  task automatic rd_isr(input string tag, input logic [7:0] exp);
    wr(0, 8'h0B, e);
    rd(0, rv); chk(tag, rv, exp);
    wr(0, 8'h0A, e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 int after reset", int_o, 0);
    chk("R10 err after reset", err_o, 0);
    chk("R10 vec_valid after reset", vec_valid_o, 0);
    rst = 0;
    rd(1, rv); chk("R10 mask reset", rv, 0);
    rd(0, rv); chk("R10 pending reset / R11 read", rv, 0);

    wr(1, 8'h33, e); chk("R4 data write before start", e, 1);
    wr(0, 8'h08, e); chk("R4 command before start", e, 1);

    // R2/R3 sweep over all four initialization shapes
    for (int mode = 0; mode < 4; mode++) begin
      logic [7:0] old_mask;
      rd(1, old_mask);
      wr(0, 8'h10 | 8'(mode), e); chk("R1 start", e, 0);
      if (mode == 0) begin
        wr(0, 8'h0A, e); chk("R4 command while awaiting base", e, 1);
      end
      wr(1, 8'h40, e); chk("R2 base", e, 0);
      if (mode[1] == 0) begin
        wr(1, 8'h5A, e); chk("R2 third", e, 0);
        rd(1, rv); chk("R2 third leaves mask", rv, old_mask);
      end
      if (mode[0] == 1) begin
        wr(1, 8'hC3, e); chk("R2 fourth", e, 0);
        rd(1, rv); chk("R2 fourth leaves mask", rv, old_mask);
      end
      wr(1, 8'hA0 | 8'(mode), e); chk("R3 mask write", e, 0);
      rd(1, rv); chk("R3 mask readback", rv, 8'hA0 | 8'(mode));
    end
    wr(1, 8'h00, e);

    // R9 vector arithmetic sweep, including wrap-around
    for (int bi = 0; bi < 3; bi++) begin
      logic [7:0] b;
      b = (bi == 0) ? 8'h20 : (bi == 1) ? 8'h08 : 8'hFC;
      init(8'h13, b);
      for (int l = 0; l < NL; l++) begin
        raise(NL'(1) << l);
        chk("R8 int for single request", int_o, 1);
        ack(vv, vec);
        chk("R9 vec_valid", vv, 1);
        chk("R9 vector", vec, (b + l) & 8'hFF);
        chk("R8 int clear after ack", int_o, 0);
        eoi();
        rd_isr("R5 in-service empty after eoi", 8'h00);
      end
    end

    // R8 full priority order
    init(8'h13, 8'h20);
    raise('1);
    rd(0, rv); chk("R7 all pending", rv, 8'hFF);
    for (int l = 0; l < NL; l++) begin
      chk("R8 int before ack", int_o, 1);
      ack(vv, vec);
      chk("R9 priority vector", vec, 8'h20 + l);
      chk("R8 lower levels blocked", int_o, 0);
      eoi();
      chk("R8 int after eoi", int_o, (l != NL - 1) ? 1 : 0);
    end

    // nesting
    raise(8'h20); ack(vv, vec); chk("R9 vec 5", vec, 8'h25);
    raise(8'h04); chk("R8 higher level preempts", int_o, 1);
    ack(vv, vec); chk("R9 nested vec", vec, 8'h22);
    wr(0, 8'h0B, e); chk("R6 select in-service", e, 0);
    rd(0, rv); chk("R6 in-service read", rv, 8'h24);
    wr(0, 8'h08, e);
    rd(0, rv); chk("R6 selection kept", rv, 8'h24);
    wr(0, 8'h20, e);
    rd(0, rv); chk("R5 lowest bit cleared", rv, 8'h20);
    wr(0, 8'h0A, e);
    rd(0, rv); chk("R6 pending read", rv, 8'h00);
    raise(8'h40); chk("R8 lower level waits", int_o, 0);
    eoi(); chk("R8 released after eoi", int_o, 1);
    ack(vv, vec); chk("R9 vec 6", vec, 8'h26);
    eoi();

    // masking
    wr(1, 8'h08, e);
    raise(8'h08); chk("R8 masked no int", int_o, 0);
    rd(0, rv); chk("R7 masked still pending", rv, 8'h08);
    ack(vv, vec); chk("R9 ack without grant", vv, 0);
    rd(0, rv); chk("R9 ack without grant no change", rv, 8'h08);
    wr(1, 8'h00, e); @(negedge clk);
    chk("R8 unmask raises int", int_o, 1);
    ack(vv, vec); chk("R9 vec 3", vec, 8'h23);
    eoi();

    // refused end-of-interrupt forms
    raise(8'h10); ack(vv, vec);
    wr(0, 8'h60, e); chk("R4 specific eoi refused", e, 1);
    rd_isr("R4 in-service untouched", 8'h10);
    wr(0, 8'hA0, e); chk("R4 rotate eoi refused", e, 1);
    rd_isr("R4 in-service untouched 2", 8'h10);
    eoi();

    // restart from the ready state
    wr(0, 8'h13, e); chk("R1 start in ready state", e, 0);
    wr(1, 8'h50, e); wr(1, 8'h00, e);
    rd(1, rv); chk("R1 data write went to base", rv, 8'h00);
    raise(8'h02); ack(vv, vec); chk("R1 new base used", vec, 8'h51);
    eoi();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule